// File: doc/BRIEF.md
# Dual-Priority Transmit Descriptor Chainer

This block sits between a host and a segmentation engine. The host hands in transmit descriptors through one of two pending queues, one urgent and one normal. Each descriptor carries a buffer pointer, the number of the virtual circuit (VC) it belongs to, a buffer length and a flag that marks the last buffer of a packet. A buffer may hold a whole packet or only a slice of one. The block moves one pending descriptor per cycle into an on-chip per-VC linked list. The urgent queue always wins.

The segmentation engine asks for the head descriptor of a VC. The block answers one cycle later with a hit or a miss. When the engine finishes a buffer, it reports that VC done. The block then unlinks the head and posts its pointer on a release queue, from which the host collects finished buffers. If the release queue is full, the done report is held off and the chain stays as it is.

Top module: `txq_chainer`

## Requirements
- R1: After reset, every VC chain is empty, `rel_valid` is 0, and `hi_ready`, `lo_ready` and `done_ready` are 1.
- R2: A descriptor offered with `hi_valid`/`lo_valid` while the matching ready is 1 is taken into that pending queue. It is linked onto its VC chain on a later cycle.
- R3: When both pending queues hold entries, the urgent (`hi_*`) entry is linked first, so it lands ahead in the chain.
- R4: Descriptors for one VC are handed out in the order in which they were linked. Each keeps its own length and end-of-packet flag.
- R5: A `req_valid` with `req_vc` on a VC that holds descriptors gives, on the next cycle, `rsp_valid`=1 and `rsp_hit`=1. The same response carries the head's pointer, length and end-of-packet flag.
- R6: A request on an empty VC gives, on the next cycle, `rsp_valid`=1 and `rsp_hit`=0, with pointer, length and flag all 0. It never stalls.
- R7: An accepted done report on a non-empty VC pushes the head pointer onto the release queue and makes the next descriptor the head. If it was the last descriptor, the VC becomes empty.
- R8: While the release queue holds `RQ_DEPTH` pointers, `done_ready` is 0, and a done report changes neither the chain nor the release queue.
- R9: An accepted done report on an empty VC releases nothing.
- R10: Released pointers come out in the order the done reports were accepted. `rel_valid` and `rel_ptr` hold steady until `rel_ready` takes the pointer.
- R11: If an append and a done report hit the same VC in the same cycle, both take effect. When the chain held one descriptor, the new one becomes head and tail.
- R12: Chains of different VCs do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_valid | input | 1 | Urgent descriptor offered |
| hi_ready | output | 1 | Urgent pending queue has room |
| hi_ptr | input | PTR_W | Urgent descriptor pointer |
| hi_vc | input | VC_W | Urgent descriptor VC |
| hi_len | input | LEN_W | Urgent descriptor buffer length |
| hi_eop | input | 1 | Urgent descriptor ends a packet |
| lo_valid | input | 1 | Normal descriptor offered |
| lo_ready | output | 1 | Normal pending queue has room |
| lo_ptr | input | PTR_W | Normal descriptor pointer |
| lo_vc | input | VC_W | Normal descriptor VC |
| lo_len | input | LEN_W | Normal descriptor buffer length |
| lo_eop | input | 1 | Normal descriptor ends a packet |
| req_valid | input | 1 | Head lookup request |
| req_vc | input | VC_W | VC being looked up |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | VC had a head descriptor |
| rsp_ptr | output | PTR_W | Head pointer (0 on miss) |
| rsp_len | output | LEN_W | Head buffer length (0 on miss) |
| rsp_eop | output | 1 | Head end-of-packet flag (0 on miss) |
| done_valid | input | 1 | Head buffer of a VC is exhausted |
| done_vc | input | VC_W | VC whose head is finished |
| done_ready | output | 1 | Done report can be taken |
| rel_valid | output | 1 | Released pointer available |
| rel_ready | input | 1 | Host takes the released pointer |
| rel_ptr | output | PTR_W | Released descriptor pointer |

## Verification
A descriptor taken at one clock edge is linked at the next edge, so the bench issues lookups only after at least one further edge. A lookup answer is due exactly one edge after `req_valid` is sampled, and the bench reads it at the following falling edge. A released pointer is visible right after the edge that accepts the done report. The monitor samples it a few nanoseconds after the falling edge and pops it only when `rel_ready` is high, which keeps the scoreboard in step with the handshake. The same-VC append/release case is lined up so that the link edge and the done edge coincide.

// File: rtl/txq_chainer.sv
module txq_chainer #(
  parameter int PTR_W    = 8,
  parameter int VC_W     = 2,
  parameter int LEN_W    = 16,
  parameter int PQ_DEPTH = 4,
  parameter int RQ_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_valid,
  output logic             hi_ready,
  input  logic [PTR_W-1:0] hi_ptr,
  input  logic [VC_W-1:0]  hi_vc,
  input  logic [LEN_W-1:0] hi_len,
  input  logic             hi_eop,
  input  logic             lo_valid,
  output logic             lo_ready,
  input  logic [PTR_W-1:0] lo_ptr,
  input  logic [VC_W-1:0]  lo_vc,
  input  logic [LEN_W-1:0] lo_len,
  input  logic             lo_eop,
  input  logic             req_valid,
  input  logic [VC_W-1:0]  req_vc,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PTR_W-1:0] rsp_ptr,
  output logic [LEN_W-1:0] rsp_len,
  output logic             rsp_eop,
  input  logic             done_valid,
  input  logic [VC_W-1:0]  done_vc,
  output logic             done_ready,
  output logic             rel_valid,
  input  logic             rel_ready,
  output logic [PTR_W-1:0] rel_ptr
);
  localparam int NVC   = 1 << VC_W;
  localparam int NDESC = 1 << PTR_W;
  localparam int PQ_AW = $clog2(PQ_DEPTH);
  localparam int RQ_AW = $clog2(RQ_DEPTH);
  localparam int ENT_W = PTR_W + VC_W + LEN_W + 1;
  localparam logic [PQ_AW:0] PQ_CAP = (PQ_AW+1)'(PQ_DEPTH);
  localparam logic [RQ_AW:0] RQ_CAP = (RQ_AW+1)'(RQ_DEPTH);

  // pending queues
  logic [ENT_W-1:0] hi_mem [PQ_DEPTH];
  logic [ENT_W-1:0] lo_mem [PQ_DEPTH];
  logic [PQ_AW:0]   hi_wp, hi_rp, lo_wp, lo_rp;
  logic [PQ_AW:0]   hi_cnt, lo_cnt;

  assign hi_cnt   = hi_wp - hi_rp;
  assign lo_cnt   = lo_wp - lo_rp;
  assign hi_ready = hi_cnt != PQ_CAP;
  assign lo_ready = lo_cnt != PQ_CAP;

  logic hi_push, lo_push, hi_pop, lo_pop;
  assign hi_push = hi_valid && hi_ready;
  assign lo_push = lo_valid && lo_ready;
  assign hi_pop  = hi_cnt != '0;
  assign lo_pop  = !hi_pop && (lo_cnt != '0);

  always_ff @(posedge clk) begin
    if (hi_push) hi_mem[hi_wp[PQ_AW-1:0]] <= {hi_ptr, hi_vc, hi_len, hi_eop};
    if (lo_push) lo_mem[lo_wp[PQ_AW-1:0]] <= {lo_ptr, lo_vc, lo_len, lo_eop};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_wp <= '0; hi_rp <= '0; lo_wp <= '0; lo_rp <= '0;
    end else begin
      if (hi_push) hi_wp <= hi_wp + 1'b1;
      if (lo_push) lo_wp <= lo_wp + 1'b1;
      if (hi_pop)  hi_rp <= hi_rp + 1'b1;
      if (lo_pop)  lo_rp <= lo_rp + 1'b1;
    end
  end

  // append side
  logic             app_go;
  logic [ENT_W-1:0] app_ent;
  logic [PTR_W-1:0] app_ptr;
  logic [VC_W-1:0]  app_vc;
  logic [LEN_W-1:0] app_len;
  logic             app_eop;

  assign app_go  = hi_pop || lo_pop;
  assign app_ent = hi_pop ? hi_mem[hi_rp[PQ_AW-1:0]] : lo_mem[lo_rp[PQ_AW-1:0]];
  assign {app_ptr, app_vc, app_len, app_eop} = app_ent;

  // descriptor store and per-VC chains
  logic [PTR_W-1:0] next_mem [NDESC];
  logic [LEN_W-1:0] len_mem  [NDESC];
  logic             eop_mem  [NDESC];
  logic [PTR_W-1:0] head [NVC];
  logic [PTR_W-1:0] tail [NVC];
  logic [NVC-1:0]   live;

  // release queue
  logic [PTR_W-1:0] rq_mem [RQ_DEPTH];
  logic [RQ_AW:0]   rq_wp, rq_rp, rq_cnt;
  logic             done_fire, pop_go, rel_pop;
  logic [PTR_W-1:0] pop_ptr;

  assign rq_cnt     = rq_wp - rq_rp;
  assign done_ready = rq_cnt != RQ_CAP;
  assign done_fire  = done_valid && done_ready;
  assign pop_go     = done_fire && live[done_vc];
  assign pop_ptr    = head[done_vc];
  assign rel_valid  = rq_cnt != '0;
  assign rel_ptr    = rq_mem[rq_rp[RQ_AW-1:0]];
  assign rel_pop    = rel_valid && rel_ready;

  always_ff @(posedge clk) begin
    if (app_go) begin
      len_mem[app_ptr] <= app_len;
      eop_mem[app_ptr] <= app_eop;
      if (live[app_vc]) next_mem[tail[app_vc]] <= app_ptr;
    end
    if (pop_go) rq_mem[rq_wp[RQ_AW-1:0]] <= pop_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= '0;
      rq_wp <= '0;
      rq_rp <= '0;
      for (int v = 0; v < NVC; v++) begin
        head[v] <= '0;
        tail[v] <= '0;
      end
    end else begin
      if (pop_go)  rq_wp <= rq_wp + 1'b1;
      if (rel_pop) rq_rp <= rq_rp + 1'b1;
      for (int v = 0; v < NVC; v++) begin
        logic a, p, single;
        a      = app_go && (app_vc == VC_W'(v));
        p      = pop_go && (done_vc == VC_W'(v));
        single = head[v] == tail[v];
        if (p && a) begin
          head[v] <= single ? app_ptr : next_mem[head[v]];
          tail[v] <= app_ptr;
        end else if (p) begin
          if (single) live[v] <= 1'b0;
          else        head[v] <= next_mem[head[v]];
        end else if (a) begin
          if (!live[v]) begin
            head[v] <= app_ptr;
            live[v] <= 1'b1;
          end
          tail[v] <= app_ptr;
        end
      end
    end
  end

  // head lookup
  logic             req_hit;
  logic [PTR_W-1:0] req_head;
  assign req_hit  = live[req_vc];
  assign req_head = head[req_vc];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ptr   <= '0;
      rsp_len   <= '0;
      rsp_eop   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && req_hit;
      rsp_ptr   <= (req_valid && req_hit) ? req_head : '0;
      rsp_len   <= (req_valid && req_hit) ? len_mem[req_head] : '0;
      rsp_eop   <= req_valid && req_hit && eop_mem[req_head];
    end
  end
endmodule

// File: rtl/txq_chainer_chk.sv
module txq_chainer_chk #(
  parameter int PTR_W    = 8,
  parameter int VC_W     = 2,
  parameter int LEN_W    = 16,
  parameter int PQ_DEPTH = 4,
  parameter int RQ_DEPTH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [PTR_W-1:0]   rsp_ptr,
  input logic [LEN_W-1:0]   rsp_len,
  input logic               rsp_eop,
  input logic               done_valid,
  input logic [VC_W-1:0]    done_vc,
  input logic               done_ready,
  input logic               rel_valid,
  input logic               rel_ready,
  input logic [PTR_W-1:0]   rel_ptr,
  input logic               lo_pop,
  input logic [$clog2(PQ_DEPTH):0] hi_cnt,
  input logic [(1<<VC_W)-1:0] live
);
  a_r5_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r6_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ptr == '0 && rsp_len == '0 && !rsp_eop));

  a_r3_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
    lo_pop |-> (hi_cnt == '0));

  a_r7_pop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_ready && live[done_vc]) |=> rel_valid);

  a_r8_full_has_backlog: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ready |-> rel_valid);

  a_r10_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_ptr)));
endmodule

bind txq_chainer txq_chainer_chk #(
  .PTR_W(PTR_W), .VC_W(VC_W), .LEN_W(LEN_W),
  .PQ_DEPTH(PQ_DEPTH), .RQ_DEPTH(RQ_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ptr(rsp_ptr),
  .rsp_len(rsp_len), .rsp_eop(rsp_eop), .done_valid(done_valid),
  .done_vc(done_vc), .done_ready(done_ready), .rel_valid(rel_valid),
  .rel_ready(rel_ready), .rel_ptr(rel_ptr), .lo_pop(lo_pop),
  .hi_cnt(hi_cnt), .live(live)
);

// File: tb/txq_chainer_test.sv
module txq_chainer_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       hi_valid = 0, lo_valid = 0, req_valid = 0, done_valid = 0, rel_ready = 1;
  logic [7:0] hi_ptr = 0, lo_ptr = 0;
  logic [1:0] hi_vc = 0, lo_vc = 0, req_vc = 0, done_vc = 0;
  logic [15:0] hi_len = 0, lo_len = 0;
  logic       hi_eop = 0, lo_eop = 0;
  logic       hi_ready, lo_ready, rsp_valid, rsp_hit, rsp_eop, done_ready, rel_valid;
  logic [7:0] rsp_ptr, rel_ptr;
  logic [15:0] rsp_len;

  int n_checks = 0, n_fails = 0, m_checks = 0, m_fails = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  txq_chainer uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input bit urgent, input int ptr, input int vc, input int len, input bit eop);
    @(negedge clk);
    if (urgent) begin hi_valid = 1; hi_ptr = 8'(ptr); hi_vc = 2'(vc); hi_len = 16'(len); hi_eop = eop; end
    else        begin lo_valid = 1; lo_ptr = 8'(ptr); lo_vc = 2'(vc); lo_len = 16'(len); lo_eop = eop; end
    @(negedge clk);
    hi_valid = 0; lo_valid = 0;
  endtask

  task automatic lookup(input int vc, input bit hit, input int ptr, input int len, input bit eop, input string tag);
    @(negedge clk);
    req_valid = 1; req_vc = 2'(vc);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, {tag, " rsp_valid"}, int'(rsp_valid), 1);
    chk(rsp_hit === hit, {tag, " rsp_hit"}, int'(rsp_hit), int'(hit));
    chk(rsp_ptr === 8'(ptr), {tag, " rsp_ptr"}, int'(rsp_ptr), ptr);
    chk(rsp_len === 16'(len), {tag, " rsp_len"}, int'(rsp_len), len);
    chk(rsp_eop === eop, {tag, " rsp_eop"}, int'(rsp_eop), int'(eop));
  endtask

  task automatic finish_buf(input int vc, input bit expect_rel, input int ptr);
    @(negedge clk);
    done_valid = 1; done_vc = 2'(vc);
    if (expect_rel) exp_q.push_back(8'(ptr));
    @(negedge clk);
    done_valid = 0;
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk);
    #2;
    if (rst_n && rel_valid && rel_ready) begin
      m_checks++;
      if (exp_q.size() == 0) begin
        m_fails++;
        $display("FAIL R9/R10 unexpected release: actual %0d expected none", rel_ptr);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rel_ptr !== e) begin
          m_fails++;
          $display("FAIL R7/R10 release order: actual %0d expected %0d", rel_ptr, e);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks + m_checks, n_fails + m_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rel_valid === 0, "R1 rel_valid", int'(rel_valid), 0);
    chk(hi_ready === 1 && lo_ready === 1, "R1 pending ready", int'({hi_ready, lo_ready}), 3);
    chk(done_ready === 1, "R1 done_ready", int'(done_ready), 1);
    lookup(0, 0, 0, 0, 0, "R1/R6 empty after reset");

    // R2/R3: both queues loaded in one cycle, urgent one leads the chain
    @(negedge clk);
    lo_valid = 1; lo_ptr = 20; lo_vc = 1; lo_len = 50;  lo_eop = 1;
    hi_valid = 1; hi_ptr = 21; hi_vc = 1; hi_len = 100; hi_eop = 0;
    @(negedge clk);
    hi_valid = 0; lo_valid = 0;
    repeat (2) @(negedge clk);
    lookup(1, 1, 21, 100, 0, "R2/R3/R5 urgent first");

    // R7/R4: release head, next one surfaces, then chain empties
    finish_buf(1, 1, 21);
    lookup(1, 1, 20, 50, 1, "R4/R7 second of chain");
    finish_buf(1, 1, 20);
    lookup(1, 0, 0, 0, 0, "R7/R6 chain emptied");

    // R12: independent chains
    push(0, 30, 0, 64, 0);
    push(0, 31, 2, 48, 1);
    push(0, 32, 0, 12, 1);
    lookup(0, 1, 30, 64, 0, "R12 vc0 head");
    lookup(2, 1, 31, 48, 1, "R12 vc2 head");
    finish_buf(0, 1, 30);
    lookup(0, 1, 32, 12, 1, "R4/R12 vc0 next");
    lookup(2, 1, 31, 48, 1, "R12 vc2 untouched");

    // R9: done on an empty VC releases nothing
    finish_buf(3, 0, 0);
    repeat (3) @(negedge clk);
    chk(rel_valid === 0, "R9 no release", int'(rel_valid), 0);

    // R8/R10: fill release queue while host is not taking
    rel_ready = 0;
    for (int i = 0; i < 5; i++) push(0, 40 + i, 3, 200 + i, i == 4);
    for (int i = 0; i < 4; i++) finish_buf(3, 1, 40 + i);
    @(negedge clk);
    chk(done_ready === 0, "R8 done_ready low when full", int'(done_ready), 0);
    chk(rel_valid === 1 && rel_ptr === 8'd40, "R10 oldest held", int'(rel_ptr), 40);
    done_valid = 1; done_vc = 3;
    repeat (2) @(negedge clk);
    done_valid = 0;
    chk(rel_ptr === 8'd40, "R10 stable while not taken", int'(rel_ptr), 40);
    lookup(3, 1, 44, 204, 1, "R8 chain unchanged");
    rel_ready = 1;
    repeat (6) @(negedge clk);
    chk(rel_valid === 0, "R10 queue drained", int'(rel_valid), 0);
    finish_buf(3, 1, 44);
    lookup(3, 0, 0, 0, 0, "R7 vc3 empty");

    // R11: append and release on one-entry chain in the same cycle
    @(negedge clk);
    hi_valid = 1; hi_ptr = 50; hi_vc = 2; hi_len = 77; hi_eop = 1;
    @(negedge clk);
    hi_valid = 0;
    done_valid = 1; done_vc = 2;
    exp_q.push_back(8'd31);
    @(negedge clk);
    done_valid = 0;
    lookup(2, 1, 50, 77, 1, "R11 new entry is head");
    finish_buf(2, 1, 50);
    lookup(2, 0, 0, 0, 0, "R11 chain empty");
    finish_buf(0, 1, 32);
    lookup(0, 0, 0, 0, 0, "R12 vc0 empty");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all releases seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks + m_checks, n_fails + m_fails);
    $finish;
  end
endmodule